// File: doc/BRIEF.md
# Bidirectional Auto-Reload Timer

This block is a 16-bit timer that reloads itself when it wraps. Its count direction can be chosen while it runs. Each step comes from one of two sources. The first is an internal tick that fires once every twelve clocks. The second is a falling edge on an external count pin, which passes through a synchronizer before it is used.

By default the timer only counts up. From all ones it wraps to the value held in a reload register. When the down-count mode is enabled, an external direction pin chooses the direction. A high level counts up. A low level counts down. When counting down, the wrap point is the reload value itself, and the timer restarts from all ones.

Every wrap sets a sticky overflow flag, and the interrupt output follows that flag. In down-count mode each wrap also flips a separate event flag, which raises no interrupt. Software programs the block through a byte-wide write port. That port reaches a control byte, a mode byte, and the separate bytes of the count and reload registers.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the count, reload, overflow flag, event flag, interrupt, run bit, source bit and down-count enable all read zero.
- R2: Address 2 writes count bits 7:0, address 3 writes count bits 15:8, address 4 writes reload bits 7:0 and address 5 writes reload bits 15:8. A count byte written in the same cycle as a step wins: the step is dropped, the other byte is kept, and no wrap occurs.
- R3: While the run bit (control byte at address 0, bit 0) is 0, the count holds its value whatever happens on the pins.
- R4: Control bit 1 selects the step source. With the bit at 0, the count advances once every 12 clocks, and the first step lands 12 clocks after run is set. With the bit at 1, each falling edge of the count pin gives one step, applied on the third rising clock edge after the pin falls.
- R5: With the down-count enable (mode byte at address 1, bit 0) at 0, the timer counts up whatever the level on the direction pin.
- R6: With the down-count enable at 1, a direction pin at 1 counts up and a direction pin at 0 counts down.
- R7: A step up from FFFFh loads the reload value into the count and sets the overflow flag.
- R8: A step down taken while the count equals the reload value loads FFFFh into the count and sets the overflow flag. Any other step down decrements the count by one.
- R9: The event flag flips on every wrap while the down-count enable is 1, and keeps its value on a wrap while the enable is 0.
- R10: The overflow flag stays set until a control write with bit 7 at 0 clears it. A control write with bit 7 at 1 leaves it unchanged. If a wrap and a clearing write happen in the same cycle, the flag is set. The interrupt output equals the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| cnt_pin_i | input | 1 | External count pin; a falling edge gives one step |
| dir_pin_i | input | 1 | Direction pin (1 up, 0 down) when down-count is enabled |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload register |
| ovf_flag_o | output | 1 | Sticky overflow/underflow flag |
| evt_flag_o | output | 1 | Event flag that flips on each wrap in down-count mode |
| irq_o | output | 1 | Interrupt request, high while the overflow flag is set |

## Verification
A register write shows up on the outputs at the first rising edge after the strobe. A falling edge on the count pin moves the count on the third rising edge, because two synchronizer flops and one edge-detect flop lie on the way. With the internal source, the first step comes twelve edges after the write that sets run. The driver tasks hold each pin level for four clocks and queue their expected state only after those edges have passed. The monitor compares on a falling clock edge. For the cases where a write and a step must collide, the write strobe is raised exactly two falling edges after the pin falls, so that both land on the same rising edge.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  // register map (byte addresses)
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_MODE     = 1;
  localparam int ADDR_CNT_BASE = 2;

  // control byte bit positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SRC_BIT  = 1;

  // mode byte bit positions
  localparam int MODE_DN_BIT   = 0;

  typedef struct packed {
    logic run;
    logic ext_src;
    logic dn_en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pcnt_q <= '0;
    end else if (pcnt_q == LAST) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (pcnt_q == LAST);

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R4
  pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= LAST);
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-1:0], pin_i};
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = sh_q[STAGES] && !sh_q[STAGES-1];

  // R4
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              up_i,
  input  logic [CNT_W/DATA_W-1:0] lane_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o
);
  localparam int LANES = CNT_W / DATA_W;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] nxt;
  logic             wrap_raw;
  logic             any_wr;

  assign any_wr = |lane_wr_i;

  always_comb begin
    nxt      = count_q;
    wrap_raw = 1'b0;
    if (step_i) begin
      if (up_i) begin
        if (count_q == '1) begin
          nxt      = reload_i;
          wrap_raw = 1'b1;
        end else begin
          nxt = count_q + 1'b1;
        end
      end else begin
        if (count_q == reload_i) begin
          nxt      = '1;
          wrap_raw = 1'b1;
        end else begin
          nxt = count_q - 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        count_q[i*DATA_W +: DATA_W] <= '0;
      end else if (any_wr) begin
        if (lane_wr_i[i]) begin
          count_q[i*DATA_W +: DATA_W] <= wr_data_i;
        end
      end else begin
        count_q[i*DATA_W +: DATA_W] <= nxt[i*DATA_W +: DATA_W];
      end
    end

    // R2
    lane_write_chk: assert property (@(posedge clk) disable iff (rst)
      lane_wr_i[i] |=> count_q[i*DATA_W +: DATA_W] == $past(wr_data_i));
  end

  assign wrap_o  = wrap_raw && !any_wr;
  assign count_o = count_q;

  // R7
  up_wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && up_i && !any_wr && count_q == '1) |=> count_q == $past(reload_i));

  // R8
  down_wrap_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !up_i && !any_wr && count_q == reload_i) |=> count_q == '1);

  // R8
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !up_i && !any_wr && count_q != reload_i)
      |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic dn_mode_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic evt_o
);
  logic ovf_q;
  logic evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (wrap_i) begin
        ovf_q <= 1'b1;
      end else if (clr_i) begin
        ovf_q <= 1'b0;
      end
      if (wrap_i && dn_mode_i) begin
        evt_q <= !evt_q;
      end
    end
  end

  assign ovf_o = ovf_q;
  assign evt_o = evt_q;

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> ovf_q);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_i) |=> ovf_q);

  // R9
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrap_i && dn_mode_i) |=> $stable(evt_q));

  // R9
  evt_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && dn_mode_i) |=> evt_q != $past(evt_q));
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cnt_pin_i,
  input  logic              dir_pin_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              ovf_flag_o,
  output logic              evt_flag_o,
  output logic              irq_o
);
  localparam int LANES         = CNT_W / DATA_W;
  localparam int ADDR_RLD_BASE = ADDR_CNT_BASE + LANES;
  localparam int CLR_BIT       = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);

  tmr_ctrl_t         ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [LANES-1:0]  cnt_lane_wr;
  logic              ctrl_wr;
  logic              mode_wr;
  logic              flag_clr;
  logic              tick;
  logic              ext_fall;
  logic              dir_level;
  logic              unused_cnt_level;
  logic              unused_dir_fall;
  logic              step;
  logic              up;
  logic              wrap;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == A_CTRL);
  assign mode_wr  = wr_en_i && (wr_addr_i == A_MODE);
  assign flag_clr = ctrl_wr && !wr_data_i[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.run     <= wr_data_i[CTRL_RUN_BIT];
        ctrl_q.ext_src <= wr_data_i[CTRL_SRC_BIT];
      end
      if (mode_wr) begin
        ctrl_q.dn_en <= wr_data_i[MODE_DN_BIT];
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADDR_CNT_BASE + i);
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(ADDR_RLD_BASE + i);

    assign cnt_lane_wr[i] = wr_en_i && (wr_addr_i == A_CNT);

    always_ff @(posedge clk) begin
      if (rst) begin
        reload_q[i*DATA_W +: DATA_W] <= '0;
      end else if (wr_en_i && (wr_addr_i == A_RLD)) begin
        reload_q[i*DATA_W +: DATA_W] <= wr_data_i;
      end
    end
  end

  tmr_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .en_i   (ctrl_q.run && !ctrl_q.ext_src),
    .tick_o (tick)
  );

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (cnt_pin_i),
    .level_o (unused_cnt_level),
    .fall_o  (ext_fall)
  );

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (dir_pin_i),
    .level_o (dir_level),
    .fall_o  (unused_dir_fall)
  );

  assign step = ctrl_q.run && (ctrl_q.ext_src ? ext_fall : tick);
  assign up   = !ctrl_q.dn_en || dir_level;

  tmr_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .up_i      (up),
    .lane_wr_i (cnt_lane_wr),
    .wr_data_i (wr_data_i),
    .reload_i  (reload_q),
    .count_o   (count_o),
    .wrap_o    (wrap)
  );

  tmr_flag_unit u_flags (
    .clk       (clk),
    .rst       (rst),
    .wrap_i    (wrap),
    .dn_mode_i (ctrl_q.dn_en),
    .clr_i     (flag_clr),
    .ovf_o     (ovf_flag_o),
    .evt_o     (evt_flag_o)
  );

  assign reload_o = reload_q;
  assign irq_o    = ovf_flag_o;

  // R3
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !(|cnt_lane_wr)) |=> $stable(count_o));

  // R5
  up_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.dn_en && step && !(|cnt_lane_wr) && count_o != '1)
      |=> count_o == $past(count_o) + 1'b1);

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == ovf_flag_o);
endmodule

// File: tb/updn_reload_timer_test.sv
module updn_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cnt_pin = 1'b1;
  logic        dir_pin = 1'b0;
  logic [15:0] count, reload;
  logic        ovf, evt, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] cnt;
    logic [15:0] rld;
    logic        ovf;
    logic        evt;
  } exp_t;

  exp_t exp_q[$];
  event samp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_reload_timer uut (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .cnt_pin_i  (cnt_pin),
    .dir_pin_i  (dir_pin),
    .count_o    (count),
    .reload_o   (reload),
    .ovf_flag_o (ovf),
    .evt_flag_o (evt),
    .irq_o      (irq)
  );

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(samp_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (count !== it.cnt || reload !== it.rld || ovf !== it.ovf ||
            evt !== it.evt || irq !== it.ovf) begin
          n_fail++;
          $display("FAIL %s: actual cnt=%h rld=%h ovf=%b evt=%b irq=%b expected cnt=%h rld=%h ovf=%b evt=%b irq=%b",
                   it.tag, count, reload, ovf, evt, irq,
                   it.cnt, it.rld, it.ovf, it.evt, it.ovf);
        end
      end
    end
  end

  task automatic expect_state(input string tag, input logic [15:0] c,
                              input logic [15:0] r, input logic o, input logic e);
    exp_t it;
    it.tag = tag; it.cnt = c; it.rld = r; it.ovf = o; it.evt = e;
    exp_q.push_back(it);
    -> samp_ev;
    #1;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    cnt_pin = 1'b0;
    repeat (4) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // pin falls, and a write is aligned to the edge that applies the step
  task automatic pulse_with_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cnt_pin = 1'b0;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_dir(input logic v);
    @(negedge clk);
    dir_pin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    expect_state("R1 reset state", 16'h0000, 16'h0000, 1'b0, 1'b0);

    reg_wr(3'd2, 8'h34);
    reg_wr(3'd3, 8'h12);
    reg_wr(3'd4, 8'h00);
    reg_wr(3'd5, 8'h80);
    expect_state("R2 byte writes", 16'h1234, 16'h8000, 1'b0, 1'b0);

    reg_wr(3'd0, 8'h82);             // external source, run off
    pulse();
    expect_state("R3 run clear holds", 16'h1234, 16'h8000, 1'b0, 1'b0);

    reg_wr(3'd0, 8'h83);             // run on
    pulse();
    expect_state("R4 external edge step", 16'h1235, 16'h8000, 1'b0, 1'b0);

    reg_wr(3'd1, 8'h00);
    set_dir(1'b0);
    pulse();
    expect_state("R5 up despite dir low", 16'h1236, 16'h8000, 1'b0, 1'b0);

    reg_wr(3'd2, 8'hFE);
    reg_wr(3'd3, 8'hFF);
    pulse();
    expect_state("R7 up to FFFF", 16'hFFFF, 16'h8000, 1'b0, 1'b0);
    pulse();
    expect_state("R7 R9 up wrap reload, evt held", 16'h8000, 16'h8000, 1'b1, 1'b0);
    pulse();
    expect_state("R10 flag sticky", 16'h8001, 16'h8000, 1'b1, 1'b0);
    reg_wr(3'd0, 8'h83);
    expect_state("R10 bit7 set keeps flag", 16'h8001, 16'h8000, 1'b1, 1'b0);
    reg_wr(3'd0, 8'h03);
    expect_state("R10 flag cleared", 16'h8001, 16'h8000, 1'b0, 1'b0);

    reg_wr(3'd1, 8'h01);             // down-count enabled, dir low
    reg_wr(3'd2, 8'h02);
    pulse();
    expect_state("R6 R8 down step", 16'h8001, 16'h8000, 1'b0, 1'b0);
    pulse();
    expect_state("R8 down reaches reload", 16'h8000, 16'h8000, 1'b0, 1'b0);
    pulse();
    expect_state("R8 R9 underflow loads ones", 16'hFFFF, 16'h8000, 1'b1, 1'b1);

    reg_wr(3'd0, 8'h03);
    set_dir(1'b1);
    pulse();
    expect_state("R6 R7 R9 up in down mode wraps", 16'h8000, 16'h8000, 1'b1, 1'b0);

    reg_wr(3'd0, 8'h03);
    reg_wr(3'd2, 8'hFF);
    reg_wr(3'd3, 8'hFF);
    pulse_with_wr(3'd2, 8'h55);
    expect_state("R2 write beats step", 16'hFF55, 16'h8000, 1'b0, 1'b0);

    reg_wr(3'd2, 8'hFF);
    pulse_with_wr(3'd0, 8'h03);
    expect_state("R10 set beats clear", 16'h8000, 16'h8000, 1'b1, 1'b1);

    reg_wr(3'd0, 8'h00);             // stop and clear flag
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd2, 8'h00);
    reg_wr(3'd3, 8'h00);
    expect_state("R3 stopped and zeroed", 16'h0000, 16'h8000, 1'b0, 1'b1);
    reg_wr(3'd0, 8'h01);             // internal source, run
    repeat (11) @(negedge clk);
    expect_state("R4 no step before 12 clocks", 16'h0000, 16'h8000, 1'b0, 1'b1);
    @(negedge clk);
    expect_state("R4 first internal step", 16'h0001, 16'h8000, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    expect_state("R4 second internal step", 16'h0002, 16'h8000, 1'b0, 1'b1);

    #1;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule